// File: doc/BRIEF.md
# Planar Read Latch and Color Compare

This block is the read side of a display memory split into four bit planes. The memory sits outside the block. It presents the four bytes stored at the current read offset, one byte per plane, on a single flat bus. When the CPU read strobe is high, the block captures all four bytes into latch registers in a single step. The write datapath next to it uses those latch registers, and they are available on an output port. In the same clock edge the block also forms the byte returned to the CPU.

The block has two useful read modes. In the select mode it returns the byte of one plane, chosen by a two-bit plane index. In the compare mode it treats each bit column across the four planes as a 4-bit pixel. It returns a byte in which every set bit marks a pixel that matches a reference color, and a care mask limits which planes take part in that comparison. The two remaining mode codes are reserved. A read with a reserved code returns zero and leaves the latches untouched.

Top module: `plane_read_latch`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `rd_data` is 0x00, `rd_valid` is 0 and all four latch bytes in `latch_out` are 0x00.
- R2: A strobe with `rd_mode` equal to 0 or 1 loads latch byte k (`latch_out[8k+7:8k]`) from plane byte k (`plane_bytes[8k+7:8k]`), for k = 0..3, on that clock edge.
- R3: The latches keep their value on every cycle without a strobe, and also on a strobe whose `rd_mode` is 2 or 3.
- R4: With `rd_mode` = 0 (select), `rd_data` becomes the byte of the plane whose index is given by `plane_sel`, where 0 selects plane 0 and 3 selects plane 3.
- R5: With `rd_mode` = 1 (compare), result bit b is computed from a 4-bit pixel. Bit b of plane k becomes bit k of that pixel.
- R6: In compare mode, result bit b is 1 exactly when ((pixel XOR `cmp_color`) AND `care_mask`) is zero.
- R7: In compare mode, a `care_mask` of 0000 returns 0xFF whatever the plane bytes and the color are.
- R8: A strobe with `rd_mode` equal to 2 or 3 returns 0x00 on `rd_data`.
- R9: `rd_data` and `rd_valid` are registered. They change on the clock edge that samples the strobe. `rd_valid` is high for exactly one cycle per strobe, and `rd_data` holds its value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | CPU read strobe, one cycle per read |
| rd_mode | input | 2 | 0 = plane select, 1 = color compare, 2/3 reserved |
| plane_sel | input | 2 | Plane returned in select mode |
| cmp_color | input | 4 | Reference pixel color for compare mode |
| care_mask | input | 4 | Planes that take part in the comparison |
| plane_bytes | input | 32 | Memory bytes at the read offset, plane k in bits 8k+7:8k |
| rd_data | output | 8 | Registered read result |
| rd_valid | output | 1 | One-cycle pulse marking a new `rd_data` |
| latch_out | output | 32 | Latch contents, plane k in bits 8k+7:8k |

## Verification
The select mode is tried with every plane index on bytes that differ from each other. A wrong index decode or a swapped byte lane therefore returns a recognisably wrong value. The compare mode uses plane patterns in which the matching bit columns are known in advance. These include a single-plane color, a two-plane color with the other planes held at all ones, a care mask that excludes every plane that disagrees, and the all-zero mask. Together they tell the pixel packing order apart from the mask polarity and from the comparison itself. Reserved-mode reads and idle cycles with a changing plane bus show whether the latches load only when they should.

// File: rtl/plane_read_pkg.sv
package plane_read_pkg;

  localparam int unsigned PLANE_COUNT = 4;
  localparam int unsigned PLANE_BITS  = 8;

  typedef enum logic [1:0] {
    RMODE_SELECT  = 2'd0,
    RMODE_COMPARE = 2'd1,
    RMODE_RSV2    = 2'd2,
    RMODE_RSV3    = 2'd3
  } read_mode_e;

  function automatic logic mode_is_planar(input logic [1:0] m);
    return (m == RMODE_SELECT) || (m == RMODE_COMPARE);
  endfunction

endpackage

// File: rtl/prl_latch_bank.sv
module prl_latch_bank #(
  parameter int unsigned PLANES = 4,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [PLANES*BYTE_W-1:0] din,
  output logic [PLANES*BYTE_W-1:0] latch_q
);

  for (genvar k = 0; k < PLANES; k++) begin : g_plane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= '0;
      end else if (load) begin
        lane_q <= din[k*BYTE_W +: BYTE_W];
      end
    end
    assign latch_q[k*BYTE_W +: BYTE_W] = lane_q;
  end

  // R2: a planar read captures every plane byte
  assert_latch_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> latch_q == $past(din));

  // R3: no load, no change
  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(latch_q));

endmodule

// File: rtl/prl_color_compare.sv
module prl_color_compare #(
  parameter int unsigned PLANES = 4,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [PLANES*BYTE_W-1:0] planes,
  input  logic [PLANES-1:0]        color,
  input  logic [PLANES-1:0]        care,
  output logic [BYTE_W-1:0]        match
);

  logic [PLANES-1:0] pixel [BYTE_W];

  always_comb begin
    for (int b = 0; b < BYTE_W; b++) begin
      for (int k = 0; k < PLANES; k++) begin
        pixel[b][k] = planes[k*BYTE_W + b];
      end
      match[b] = ~|((pixel[b] ^ color) & care);
    end
  end

endmodule

// File: rtl/prl_plane_mux.sv
module prl_plane_mux #(
  parameter int unsigned PLANES = 4,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned SEL_W = (PLANES > 1) ? $clog2(PLANES) : 1
) (
  input  logic [PLANES*BYTE_W-1:0] planes,
  input  logic [SEL_W-1:0]         sel,
  output logic [BYTE_W-1:0]        byte_out
);

  always_comb begin
    byte_out = '0;
    for (int k = 0; k < PLANES; k++) begin
      if (sel == SEL_W'(k)) byte_out = planes[k*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/plane_read_latch.sv
module plane_read_latch
  import plane_read_pkg::*;
#(
  parameter int unsigned PLANES = PLANE_COUNT,
  parameter int unsigned BYTE_W = PLANE_BITS,
  localparam int unsigned SEL_W = (PLANES > 1) ? $clog2(PLANES) : 1,
  localparam int unsigned BUS_W = PLANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic [1:0]        rd_mode,
  input  logic [SEL_W-1:0]  plane_sel,
  input  logic [PLANES-1:0] cmp_color,
  input  logic [PLANES-1:0] care_mask,
  input  logic [BUS_W-1:0]  plane_bytes,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [BUS_W-1:0]  latch_out
);

  read_mode_e        mode;
  logic              planar_rd;
  logic [BYTE_W-1:0] sel_byte;
  logic [BYTE_W-1:0] cmp_byte;
  logic [BYTE_W-1:0] result;
  logic [BYTE_W-1:0] data_q;
  logic              valid_q;

  assign mode      = read_mode_e'(rd_mode);
  assign planar_rd = rd_stb && mode_is_planar(rd_mode);

  prl_latch_bank #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .load    (planar_rd),
    .din     (plane_bytes),
    .latch_q (latch_out)
  );

  // The latches take the bus on this same edge, so the bus is the new latch value.
  prl_plane_mux #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_mux (
    .planes   (plane_bytes),
    .sel      (plane_sel),
    .byte_out (sel_byte)
  );

  prl_color_compare #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_cmp (
    .planes (plane_bytes),
    .color  (cmp_color),
    .care   (care_mask),
    .match  (cmp_byte)
  );

  always_comb begin
    unique case (mode)
      RMODE_SELECT:  result = sel_byte;
      RMODE_COMPARE: result = cmp_byte;
      default:       result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_stb;
      if (rd_stb) data_q <= result;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;

  // R4: select mode returns the latch picked by the plane index
  assert_select_matches_latch_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_mode == 2'd0) |=>
      rd_data == latch_out[$past(plane_sel)*BYTE_W +: BYTE_W]);

  // R7: empty care mask matches every pixel
  assert_empty_mask_all_ones_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_mode == 2'd1 && care_mask == '0) |=> rd_data == '1);

  // R8: reserved modes read as zero and leave the latches alone
  assert_reserved_mode_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_mode[1]) |=> (rd_data == '0) && $stable(latch_out));

  // R9: one valid pulse per strobe, data held between strobes
  assert_valid_follows_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_valid);
  assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> !rd_valid);
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));

endmodule

// File: tb/plane_read_latch_bench.sv
module plane_read_latch_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  // {mode[1:0], sel[1:0], color[3:0], care[3:0], planes[31:0], expected[7:0]}
  localparam logic [51:0] VECS [NVEC] = '{
    {2'd0, 2'd0, 4'h0, 4'h0, 32'h44332211, 8'h11},  // R4 plane 0
    {2'd0, 2'd3, 4'h0, 4'h0, 32'h44332211, 8'h44},  // R4 plane 3
    {2'd0, 2'd2, 4'h0, 4'h0, 32'hA5C30FF0, 8'hC3},  // R4 plane 2
    {2'd0, 2'd1, 4'h0, 4'h0, 32'hA5C30FF0, 8'h0F},  // R4 plane 1
    {2'd1, 2'd0, 4'hF, 4'hF, 32'hFFFFFFFF, 8'hFF},  // R6 all ones
    {2'd1, 2'd0, 4'h0, 4'hF, 32'h00000000, 8'hFF},  // R6 all zero
    {2'd1, 2'd0, 4'h1, 4'hF, 32'h0000000F, 8'h0F},  // R5 plane 0 only
    {2'd1, 2'd0, 4'h5, 4'hF, 32'h003C00F0, 8'h30},  // R5 planes 0,2
    {2'd1, 2'd0, 4'h5, 4'h5, 32'hFF3CFFF0, 8'h30},  // R6 masked planes 1,3
    {2'd1, 2'd0, 4'h9, 4'h0, 32'h12345678, 8'hFF},  // R7 empty mask
    {2'd1, 2'd0, 4'h8, 4'h8, 32'h8155AA00, 8'h81},  // R5 plane 3 bit
    {2'd1, 2'd0, 4'h0, 4'h3, 32'h00FF330F, 8'hC0},  // R6 partial mask
    {2'd2, 2'd0, 4'h0, 4'hF, 32'hDEADBEEF, 8'h00}   // R8 reserved
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_stb = 1'b0;
  logic [1:0]  rd_mode = '0;
  logic [1:0]  plane_sel = '0;
  logic [3:0]  cmp_color = '0;
  logic [3:0]  care_mask = '0;
  logic [31:0] plane_bytes = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [31:0] latch_out;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_latch = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plane_read_latch u_plane_read_latch (
    .clk, .rst, .rd_stb, .rd_mode, .plane_sel, .cmp_color, .care_mask,
    .plane_bytes, .rd_data, .rd_valid, .latch_out
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [1:0] m, input logic [1:0] s, input logic [3:0] c,
                         input logic [3:0] k, input logic [31:0] p);
    @(negedge clk);
    rd_stb = 1'b1; rd_mode = m; plane_sel = s; cmp_color = c; care_mask = k; plane_bytes = p;
    @(negedge clk);
    rd_stb = 1'b0;
    if (m < 2'd2) exp_latch = p;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 data", {24'h0, rd_data}, 32'h0);
    check("R1 valid", {31'h0, rd_valid}, 32'h0);
    check("R1 latch", latch_out, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 latch after release", latch_out, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      do_read(VECS[i][51:50], VECS[i][49:48], VECS[i][47:44], VECS[i][43:40], VECS[i][39:8]);
      check($sformatf("R4/R5/R6/R7/R8 vec%0d data", i), {24'h0, rd_data}, {24'h0, VECS[i][7:0]});
      check($sformatf("R2/R3 vec%0d latch", i), latch_out, exp_latch);
      check($sformatf("R9 vec%0d valid", i), {31'h0, rd_valid}, 32'h1);
    end

    // R8: mode 3 reserved, latches kept
    do_read(2'd0, 2'd1, 4'h0, 4'h0, 32'h0BADF00D);
    do_read(2'd3, 2'd1, 4'h0, 4'h0, 32'h12345678);
    check("R8 mode3 data", {24'h0, rd_data}, 32'h0);
    check("R3 mode3 latch kept", latch_out, 32'h0BADF00D);

    // R3/R9: idle cycles with a moving bus change nothing
    do_read(2'd0, 2'd2, 4'h0, 4'h0, 32'h77665544);
    check("R4 directed", {24'h0, rd_data}, 32'h66);
    for (int j = 0; j < 4; j++) begin
      plane_bytes = 32'hFFFF0000 + j; rd_mode = 2'd0; plane_sel = 2'd0;
      @(negedge clk);
      check("R9 valid low when idle", {31'h0, rd_valid}, 32'h0);
      check("R9 data held", {24'h0, rd_data}, 32'h66);
      check("R3 latch held", latch_out, 32'h77665544);
    end

    // R9: back-to-back strobes give two fresh results
    @(negedge clk);
    rd_stb = 1'b1; rd_mode = 2'd0; plane_sel = 2'd0; plane_bytes = 32'h0403020A;
    @(negedge clk);
    check("R9 b2b first", {24'h0, rd_data}, 32'h0A);
    plane_sel = 2'd3; plane_bytes = 32'hB0000000;
    @(negedge clk);
    rd_stb = 1'b0;
    check("R9 b2b second", {24'h0, rd_data}, 32'hB0);
    check("R2 b2b latch", latch_out, 32'hB0000000);
    check("R9 b2b valid", {31'h0, rd_valid}, 32'h1);

    // R1: reset mid-run clears state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid reset latch", latch_out, 32'h0);
    check("R1 mid reset data", {24'h0, rd_data}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule